// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a four-wire serial peripheral slave that lets an external controller set and inspect a small bank of byte-wide configuration registers and an eight-entry power-amplifier level table. The chip-select, serial clock and serial data input are asynchronous to the block's own clock. They are resynchronized and the serial clock edges are detected in the system clock domain. The serial data output is delivered as a data bit plus an output-enable, which the pad ring turns into a three-state pin.

Every selection begins with a header byte. Bit 7 chooses read (1) or write (0), bit 6 chooses burst (1) or single-byte (0) access, and bits 5..0 hold the address. One address (default 0x3E) selects the level table. Addresses below the register count select registers, and every other address is empty. The level table is not addressed per entry. A private index selects the entry, steps once per table data byte, wraps after the last entry, and returns to entry 0 whenever chip-select is high. A sleep input wipes the table.

Register and table contents are presented continuously as flat parallel buses, so the consuming logic reads them directly and no handshake or back-pressure applies. The serial side has no flow control either: the controller's clock paces every byte.

Top module: `spi_cfg_slave`

## Requirements
- R1: The output-enable `spi_miso_oe` is 0 whenever chip-select is high and 1 while it is low (after the synchronizer delay).
- R2: Input bits are captured on rising serial clock edges, most significant bit first. The header holds read/write in bit 7, burst in bit 6 and the address in bits 5..0.
- R3: While the header is shifted in, the output returns `status_in` MSB first. Output bits change only after falling serial clock edges.
- R4: In a register write, the output repeats the status byte during the data byte, and the received byte appears on `cfg_regs` bits [8*a+7:8*a] once the byte completes.
- R5: In a register read, the byte after the header returns the addressed register MSB first. Addresses at or above NREG that are not the table address read as 0 and ignore writes.
- R6: In burst register access the address advances by one per data byte and wraps from 0x3F to 0x00.
- R7: In single access, the byte that follows the one data byte is decoded as a new header within the same selection.
- R8: Table address 0x3E reaches the entry chosen by the table index. The index steps after every table data byte, read or write, and wraps from 7 to 0. Entry k appears on `pa_table` bits [8*k+7:8*k].
- R9: The table index returns to 0 while chip-select is high. A single table write followed by a single table read in the same selection returns entry 1. The same read in a new selection returns entry 0.
- R10: While `sleep_in` is high every table entry is cleared to 0. Registers keep their values.
- R11: If chip-select rises partway through a byte, the partial byte is dropped, nothing is updated, and the next selection starts with a fresh header.
- R12: After reset all registers and table entries are 0 and the output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip-select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock, idle low, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out bit |
| spi_miso_oe | output | 1 | Drive enable for the serial data out pad |
| status_in | input | 8 | Status byte returned during headers and write data |
| sleep_in | input | 1 | Clears the level table while high |
| cfg_regs | output | 8*NREG | Flat register contents, register a at bits [8a+7:8a] |
| pa_table | output | 8*TBL_DEPTH | Flat table contents, entry k at bits [8k+7:8k] |

## Verification
The bench builds the block with its defaults: eight registers, an eight-entry table at address 0x3E and two synchronizer stages, with each serial clock phase lasting ten system clocks. With these settings every one of the 64 header addresses can be read back, every register can be written and checked, and the whole table including its index wrap fits within a few selections. The sweep therefore covers empty addresses, the 0x3F-to-0x00 burst wrap and the table index behaviour around chip-select and sleep.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 3;
  localparam int ADDR_W = 6;

  typedef enum logic {PH_HDR, PH_DATA} phase_e;

  typedef struct packed {
    logic              rd;
    logic              burst;
    logic [ADDR_W-1:0] addr;
  } hdr_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_a,
  input  logic sclk_a,
  input  logic si_a,
  output logic csn_s,
  output logic si_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall
);
  // bit 0 chip-select, bit 1 serial clock, bit 2 data
  localparam logic [2:0] IDLE = 3'b001;
  logic [2:0] pipe [STAGES];
  logic [2:0] last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe[g] <= IDLE;
      else if (g == 0) pipe[g] <= {si_a, sclk_a, csn_a};
      else             pipe[g] <= pipe[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= IDLE;
    else        last <= pipe[STAGES-1];
  end

  assign csn_s     = pipe[STAGES-1][0];
  assign si_s      = pipe[STAGES-1][2];
  assign sclk_rise =  pipe[STAGES-1][1] & ~last[1];
  assign sclk_fall = ~pipe[STAGES-1][1] &  last[1];
  assign cs_fall   = ~pipe[STAGES-1][0] &  last[0];
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              si,
  input  logic [BYTE_W-1:0] first_byte,
  input  logic [BYTE_W-1:0] next_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_full,
  output logic              so_bit
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              primed;

  assign rx_full   = {rx_q[BYTE_W-2:0], si};
  assign byte_done = cs_active & sclk_rise & (bit_cnt == CNT_W'(BYTE_W-1));
  assign so_bit    = tx_q[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      primed  <= 1'b0;
    end else if (!cs_active) begin
      bit_cnt <= '0;
      rx_q    <= '0;
      primed  <= 1'b0;
    end else begin
      if (cs_fall)
        tx_q <= first_byte;
      else if (sclk_fall)
        tx_q <= (primed && bit_cnt == '0) ? next_byte : {tx_q[BYTE_W-2:0], 1'b0};
      if (sclk_rise) begin
        rx_q    <= rx_full;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W-1)) primed <= 1'b1;
      end
    end
  end

  assert_partial_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (bit_cnt == '0 && !primed));

  assert_status_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && cs_active) |=> so_bit == $past(first_byte[BYTE_W-1]));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] flat
);
  logic [BYTE_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))    regs[g] <= wr_data;
    end
    assign flat[g*BYTE_W +: BYTE_W] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end

  assert_empty_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NREG) |=> $stable(flat));
endmodule

// File: rtl/spi_pa_table.sv
module spi_pa_table
  import spi_cfg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    idx_clr,
  input  logic                    wr_en,
  input  logic                    rd_adv,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [BYTE_W-1:0]       rd_cur,
  output logic [BYTE_W-1:0]       rd_nxt,
  output logic [DEPTH*BYTE_W-1:0] flat
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH-1);

  logic [BYTE_W-1:0] ent [DEPTH];
  logic [IDX_W-1:0]  idx, idx_nx;
  logic              step;

  assign step   = wr_en | rd_adv;
  assign idx_nx = (idx == LAST) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (idx_clr) idx <= '0;
    else if (step)    idx <= idx_nx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ent[g] <= '0;
      else if (sleep)                          ent[g] <= '0;
      else if (wr_en && idx == IDX_W'(g))      ent[g] <= wr_data;
    end
    assign flat[g*BYTE_W +: BYTE_W] = ent[g];
  end

  assign rd_cur = ent[idx];
  assign rd_nxt = ent[idx_nx];

  assert_sleep_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> flat == '0);

  assert_idx_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_clr && idx == LAST) |=> idx == '0);

  assert_idx_home_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> idx == '0);
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int              NREG        = 8,
  parameter int              TBL_DEPTH   = 8,
  parameter logic [5:0]      TBL_ADDR    = 6'h3E,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        spi_csn,
  input  logic                        spi_sclk,
  input  logic                        spi_mosi,
  output logic                        spi_miso,
  output logic                        spi_miso_oe,
  input  logic [7:0]                  status_in,
  input  logic                        sleep_in,
  output logic [NREG*8-1:0]           cfg_regs,
  output logic [TBL_DEPTH*8-1:0]      pa_table
);
  logic csn_s, si_s, sclk_rise, sclk_fall, cs_fall, cs_active;
  logic byte_done;
  logic [BYTE_W-1:0] rx_full, tx_next, reg_rd, tbl_cur, tbl_nxt;
  hdr_t hdr_in;
  phase_e phase;
  logic rd_q, burst_q, tbl_q;
  logic [ADDR_W-1:0] addr_q, reg_rd_addr;
  logic data_step, reg_wr_en, tbl_wr_en, tbl_adv;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .csn_a(spi_csn), .sclk_a(spi_sclk), .si_a(spi_mosi),
    .csn_s(csn_s), .si_s(si_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall));

  assign cs_active = ~csn_s;

  spi_shift_engine u_shift (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si(si_s),
    .first_byte(status_in), .next_byte(tx_next),
    .byte_done(byte_done), .rx_full(rx_full), .so_bit(spi_miso));

  assign spi_miso_oe = cs_active;
  assign hdr_in      = hdr_t'(rx_full);
  assign reg_rd_addr = (phase == PH_HDR) ? hdr_in.addr : addr_q + 1'b1;
  assign data_step   = byte_done && phase == PH_DATA;
  assign reg_wr_en   = data_step && !rd_q && !tbl_q;
  assign tbl_wr_en   = data_step && !rd_q &&  tbl_q;
  assign tbl_adv     = data_step &&  rd_q &&  tbl_q;

  spi_reg_bank #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(addr_q),
    .wr_data(rx_full), .rd_addr(reg_rd_addr), .rd_data(reg_rd), .flat(cfg_regs));

  spi_pa_table #(.DEPTH(TBL_DEPTH)) u_tbl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep_in), .idx_clr(!cs_active),
    .wr_en(tbl_wr_en), .rd_adv(tbl_adv), .wr_data(rx_full),
    .rd_cur(tbl_cur), .rd_nxt(tbl_nxt), .flat(pa_table));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HDR;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      tbl_q   <= 1'b0;
      addr_q  <= '0;
      tx_next <= '0;
    end else if (!cs_active) begin
      phase <= PH_HDR;
    end else if (byte_done) begin
      if (phase == PH_HDR) begin
        phase   <= PH_DATA;
        rd_q    <= hdr_in.rd;
        burst_q <= hdr_in.burst;
        tbl_q   <= (hdr_in.addr == TBL_ADDR);
        addr_q  <= hdr_in.addr;
        if (!hdr_in.rd)                   tx_next <= status_in;
        else if (hdr_in.addr == TBL_ADDR) tx_next <= tbl_cur;
        else                              tx_next <= reg_rd;
      end else if (burst_q) begin
        if (!tbl_q) addr_q <= addr_q + 1'b1;
        if (!rd_q)       tx_next <= status_in;
        else if (tbl_q)  tx_next <= tbl_nxt;
        else             tx_next <= reg_rd;
      end else begin
        phase   <= PH_HDR;
        tx_next <= status_in;
      end
    end
  end

  assert_single_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && !burst_q) |=> phase == PH_HDR);

  assert_idle_header_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> phase == PH_HDR);

  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_step && burst_q && !tbl_q && cs_active) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
  localparam int NREG = 8;
  localparam int TD   = 8;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0, sleep = 1'b0;
  logic [7:0] status = 8'h00;
  logic miso, miso_oe;
  logic [NREG*8-1:0] cfg;
  logic [TD*8-1:0]   tbl;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  logic [7:0] mreg [NREG];
  logic [7:0] mtbl [TD];
  bit oe_seen;

  always #2.5 clk = ~clk;

  spi_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .status_in(status), .sleep_in(sleep),
    .cfg_regs(cfg), .pa_table(tbl));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shifts nbits from tx_b (MSB first per byte), then releases chip-select
  task automatic xfer(input int nbits);
    oe_seen = 1'b1;
    csn = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < nbits; k++) begin
      mosi = tx_b[k/8][7 - (k%8)];
      wait_clk(HALF);
      rx_b[k/8][7 - (k%8)] = miso;
      if (!miso_oe) oe_seen = 1'b0;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(2*HALF);
  endtask

  function automatic logic [7:0] regval(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
    for (int i = 0; i < TD; i++)   mtbl[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R12 reset state
    chk(cfg == '0, "R12 regs zero", cfg, 0);
    chk(tbl == '0, "R12 table zero", tbl, 0);
    chk(miso_oe == 1'b0, "R12 oe low", miso_oe, 0);

    // R4 write every register, single access
    for (int a = 0; a < NREG; a++) begin
      status = 8'h5A ^ 8'(a);
      tx_b[0] = 8'(a); tx_b[1] = regval(a);
      xfer(16);
      mreg[a] = regval(a);
      chk(rx_b[0] == status, "R3 status on header", rx_b[0], status);
      chk(rx_b[1] == status, "R4 status on write data", rx_b[1], status);
      chk(cfg[a*8 +: 8] == mreg[a], "R4 register output", cfg[a*8 +: 8], mreg[a]);
      chk(oe_seen, "R1 oe high while selected", oe_seen, 1);
      chk(miso_oe == 1'b0, "R1 oe low when deselected", miso_oe, 0);
    end

    // R2 R5 read sweep over every header address
    for (int a = 0; a < 64; a++) begin
      logic [7:0] e;
      status = 8'(a * 3);
      e = (a < NREG) ? mreg[a] : ((a == 'h3E) ? mtbl[0] : 8'h00);
      tx_b[0] = 8'h80 | 8'(a); tx_b[1] = 8'hFF;
      xfer(16);
      chk(rx_b[0] == status, "R3 status on read header", rx_b[0], status);
      chk(rx_b[1] == e, "R5 read data", rx_b[1], e);
    end

    // R5 writes to empty addresses are ignored
    for (int a = NREG; a < 64; a++) begin
      if (a == 'h3E) continue;
      tx_b[0] = 8'(a); tx_b[1] = 8'hEE;
      xfer(16);
    end
    for (int a = 0; a < NREG; a++)
      chk(cfg[a*8 +: 8] == mreg[a], "R5 empty write ignored", cfg[a*8 +: 8], mreg[a]);
    chk(tbl == '0, "R5 table untouched", tbl, 0);

    // R7 single write then new header in same selection
    status = 8'hC4;
    tx_b[0] = 8'h01; tx_b[1] = 8'h11; tx_b[2] = 8'h81; tx_b[3] = 8'h00;
    xfer(32);
    mreg[1] = 8'h11;
    chk(rx_b[2] == status, "R7 second header returns status", rx_b[2], status);
    chk(rx_b[3] == 8'h11, "R7 second header read", rx_b[3], 8'h11);

    // R6 burst write with 0x3F -> 0x00 wrap
    tx_b[0] = 8'h7F; tx_b[1] = 8'h99; tx_b[2] = 8'h42;
    xfer(24);
    mreg[0] = 8'h42;
    chk(cfg[7:0] == 8'h42, "R6 burst wrap to address 0", cfg[7:0], 8'h42);
    // R6 burst write 6,7 and empty 8
    tx_b[0] = 8'h46; tx_b[1] = 8'hD6; tx_b[2] = 8'hD7; tx_b[3] = 8'hD8;
    xfer(32);
    mreg[6] = 8'hD6; mreg[7] = 8'hD7;
    chk(cfg[55:48] == 8'hD6 && cfg[63:56] == 8'hD7, "R6 burst write", cfg[63:48], {8'hD7, 8'hD6});
    // R6 burst read 0..7
    tx_b[0] = 8'hC0;
    xfer(72);
    for (int a = 0; a < NREG; a++)
      chk(rx_b[a+1] == mreg[a], "R6 burst read", rx_b[a+1], mreg[a]);

    // R8 burst table write and read with wrap
    tx_b[0] = 8'h7E;
    for (int k = 0; k < TD; k++) begin
      tx_b[k+1] = 8'((k * 29 + 3) & 255);
      mtbl[k] = tx_b[k+1];
    end
    xfer(8 * (TD + 1));
    for (int k = 0; k < TD; k++)
      chk(tbl[k*8 +: 8] == mtbl[k], "R8 table write", tbl[k*8 +: 8], mtbl[k]);
    tx_b[0] = 8'hFE;
    xfer(8 * (TD + 2));
    for (int k = 0; k <= TD; k++)
      chk(rx_b[k+1] == mtbl[k % TD], "R8 table burst read wrap", rx_b[k+1], mtbl[k % TD]);

    // R8 burst write wraps index 7 -> 0
    tx_b[0] = 8'h7E;
    for (int k = 0; k <= TD; k++) tx_b[k+1] = 8'h10 + 8'(k);
    xfer(8 * (TD + 2));
    for (int k = 0; k < TD; k++) mtbl[k] = 8'h10 + 8'(k);
    mtbl[0] = 8'h10 + 8'(TD);
    chk(tbl[7:0] == mtbl[0], "R8 write wrap overwrites entry 0", tbl[7:0], mtbl[0]);

    // R9 index behaviour around chip-select
    tx_b[0] = 8'h3E; tx_b[1] = 8'hC3; tx_b[2] = 8'hBE; tx_b[3] = 8'h00;
    xfer(32);
    mtbl[0] = 8'hC3;
    chk(rx_b[3] == mtbl[1], "R9 read in same selection gets entry 1", rx_b[3], mtbl[1]);
    tx_b[0] = 8'hBE; tx_b[1] = 8'h00;
    xfer(16);
    chk(rx_b[1] == 8'hC3, "R9 read after deselect gets entry 0", rx_b[1], 8'hC3);

    // R10 sleep clears table, keeps registers
    sleep = 1'b1; wait_clk(4); sleep = 1'b0; wait_clk(2);
    chk(tbl == '0, "R10 table wiped", tbl, 0);
    for (int a = 0; a < NREG; a++)
      chk(cfg[a*8 +: 8] == mreg[a], "R10 registers kept", cfg[a*8 +: 8], mreg[a]);
    tx_b[0] = 8'hBE; tx_b[1] = 8'h00;
    xfer(16);
    chk(rx_b[1] == 8'h00, "R10 table reads zero", rx_b[1], 0);

    // R11 abort mid data byte and mid header
    tx_b[0] = 8'h02; tx_b[1] = 8'hFF;
    xfer(12);
    chk(cfg[23:16] == mreg[2], "R11 partial data dropped", cfg[23:16], mreg[2]);
    tx_b[0] = 8'h03;
    xfer(5);
    tx_b[0] = 8'h83; tx_b[1] = 8'h00;
    xfer(16);
    chk(rx_b[1] == mreg[3], "R11 fresh header after abort", rx_b[1], mreg[3]);
    tx_b[0] = 8'h3E; tx_b[1] = 8'h77;
    xfer(11);
    chk(tbl == '0, "R11 partial table write dropped", tbl, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule